// File: doc/BRIEF.md
# Bus-Matching Endian Width Converter

This block sits between the read side of a long-word buffer and a narrower consumer. It takes 36-bit long words from a valid/ready stream and presents each one on an output valid/ready stream as one 36-bit transfer, two 18-bit transfers or four 9-bit transfers. The upstream long word is held until its final part has been accepted downstream. Only then is it popped.

The output width and the order of the parts are fixed while reset is asserted. A bus-match pin chooses between long-word passthrough and a narrow mode. In a narrow mode, a size pin chooses between bytes and words. An endian pin chooses whether the most significant or the least significant part leaves first. After reset these pins are ignored, so the consumer sees a stable configuration for the whole run.

Top module: `bus_width_adapter`

## Requirements
- R1: While `rst_n` is low, the mode is captured on each rising clock edge. `cfg_narrow` low selects long-word mode, with 36 bits in one transfer. `cfg_narrow` high with `cfg_byte` high selects byte mode, with 9 bits in four transfers. `cfg_narrow` high with `cfg_byte` low selects word mode, with 18 bits in two transfers.
- R2: `cfg_msb_first` is captured together with the mode while reset is low. A value of 1 selects most-significant-part-first order, and 0 selects least-significant-part-first order.
- R3: In most-significant-first order, byte mode emits `in_data[35:27]`, then `[26:18]`, then `[17:9]`, then `[8:0]`. Word mode emits `[35:18]` and then `[17:0]`.
- R4: In least-significant-first order, the parts come out in the reverse sequence. Byte mode emits `[8:0]` first and `[35:27]` last. Word mode emits `[17:0]` first.
- R5: Changes on `cfg_narrow`, `cfg_byte` and `cfg_msb_first` while `rst_n` is high have no effect on the width or the order.
- R6: `in_ready` is high only in a cycle where `out_ready` is high and the current part is the last part of the long word. Each long word is therefore popped exactly once, on its final output handshake.
- R7: In long-word mode the data passes through with no register on the path. `out_data` equals `in_data`, and `in_ready` equals `out_ready`.
- R8: The part counter is zero after reset. It advances only on a cycle with `out_valid` and `out_ready` both high, and it returns to zero after the last part. A stall holds the current part on the output.
- R9: Output bits above the active width are 0 in byte mode (`out_data[35:9]`) and in word mode (`out_data[35:18]`).
- R10: `out_valid` equals `in_valid` in every cycle. No data is buffered inside the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_narrow | input | 1 | Bus-match select: 1 = narrow port, 0 = full long word |
| cfg_byte | input | 1 | Narrow size select: 1 = 9-bit byte, 0 = 18-bit word |
| cfg_msb_first | input | 1 | Order select: 1 = most significant part first |
| in_data | input | 36 | Upstream long word |
| in_valid | input | 1 | Upstream word present |
| in_ready | output | 1 | Pop of the upstream word |
| out_data | output | 36 | Current part, zero-extended |
| out_valid | output | 1 | Output part valid |
| out_ready | input | 1 | Consumer accepts the part |

## Verification
The bench goes after part ordering in all six configurations. A swapped slice index would emit the parts in reverse or repeat one of them, and the expected values are computed with shift and mask arithmetic that the bench writes its own way. It inserts random output stalls inside a long word. A counter that advanced without a handshake would skip a part, and an early pop would raise `in_ready` before the last part. It toggles the configuration pins after reset, which catches a design that samples them live. It also resets in the middle of a word, which catches a counter that does not clear.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic [1:0] {
    MODE_LONG = 2'd0,
    MODE_WORD = 2'd1,
    MODE_BYTE = 2'd2
  } bwa_mode_e;

  typedef struct packed {
    bwa_mode_e mode;
    logic      msb_first;
  } bwa_cfg_t;

  // Map the two configuration pins onto a transfer mode.
  function automatic bwa_mode_e decode_mode(input logic narrow, input logic bytesel);
    if (!narrow)      return MODE_LONG;
    else if (bytesel) return MODE_BYTE;
    else              return MODE_WORD;
  endfunction

  // Number of transfers per long word, minus one.
  function automatic int unsigned last_part_of(input bwa_mode_e m, input int unsigned lanes);
    case (m)
      MODE_LONG: return 0;
      MODE_WORD: return (lanes / 2) - 1;
      default:   return lanes - 1;
    endcase
  endfunction

  // Physical slice index for sequence position seq.
  function automatic int unsigned phys_slot(input int unsigned seq, input int unsigned last,
                                            input logic msb_first);
    return msb_first ? (last - seq) : seq;
  endfunction

endpackage

// File: rtl/bwa_cfg_latch.sv
module bwa_cfg_latch
  import bwa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_narrow,
  input  logic     pin_byte,
  input  logic     pin_msb_first,
  output bwa_cfg_t cfg_q
);

  // Pins are followed only while reset is held; afterwards the value is frozen.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.mode      <= decode_mode(pin_narrow, pin_byte);
      cfg_q.msb_first <= pin_msb_first;
    end
  end

endmodule

// File: rtl/bwa_part_counter.sv
module bwa_part_counter #(
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_fire,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] idx_q,
  output logic             is_last
);

  assign is_last = (idx_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (beat_fire) begin
      idx_q <= is_last ? '0 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/bwa_part_mux.sv
module bwa_part_mux
  import bwa_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  parameter int unsigned IDX_W  = 2,
  localparam int unsigned DATA_W = LANE_W * LANES,
  localparam int unsigned WORD_W = 2 * LANE_W,
  localparam int unsigned HALVES = LANES / 2,
  localparam int unsigned HIDX_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  bwa_mode_e         mode,
  input  logic [IDX_W-1:0]  phys_idx,
  input  logic [DATA_W-1:0] long_word,
  output logic [DATA_W-1:0] part_out
);

  logic [LANE_W-1:0] lane_slice [LANES];
  logic [WORD_W-1:0] half_slice [HALVES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_slice[g] = long_word[g*LANE_W +: LANE_W];
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign half_slice[h] = long_word[h*WORD_W +: WORD_W];
  end

  always_comb begin
    part_out = '0;
    case (mode)
      MODE_LONG: part_out = long_word;
      MODE_WORD: part_out[WORD_W-1:0] = half_slice[phys_idx[HIDX_W-1:0]];
      default:   part_out[LANE_W-1:0] = lane_slice[phys_idx];
    endcase
  end

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DATA_W = LANE_W * LANES,
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_narrow,
  input  logic              cfg_byte,
  input  logic              cfg_msb_first,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);

  bwa_cfg_t         cfg_q;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] part_idx;
  logic [IDX_W-1:0] phys_idx;
  logic             part_last;
  logic             beat_fire;

  bwa_cfg_latch u_cfg (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_narrow    (cfg_narrow),
    .pin_byte      (cfg_byte),
    .pin_msb_first (cfg_msb_first),
    .cfg_q         (cfg_q)
  );

  assign last_idx  = IDX_W'(last_part_of(cfg_q.mode, LANES));
  assign phys_idx  = IDX_W'(phys_slot(32'(part_idx), 32'(last_idx), cfg_q.msb_first));
  assign out_valid = in_valid;
  assign beat_fire = out_valid && out_ready;
  assign in_ready  = out_ready && part_last;

  bwa_part_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_fire (beat_fire),
    .last_idx  (last_idx),
    .idx_q     (part_idx),
    .is_last   (part_last)
  );

  bwa_part_mux #(.LANE_W(LANE_W), .LANES(LANES), .IDX_W(IDX_W)) u_mux (
    .mode      (cfg_q.mode),
    .phys_idx  (phys_idx),
    .long_word (in_data),
    .part_out  (out_data)
  );

endmodule

// File: rtl/bwa_checker.sv
module bwa_checker
  import bwa_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DATA_W = LANE_W * LANES,
  localparam int unsigned WORD_W = 2 * LANE_W,
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input bwa_cfg_t          cfg_q,
  input logic [IDX_W-1:0]  part_idx,
  input logic [IDX_W-1:0]  last_idx,
  input logic              part_last,
  input logic              beat_fire,
  input logic [DATA_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_ready
);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(cfg_q)); // R5

  AST_POP_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (out_valid && out_ready && part_last)); // R6

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    part_idx <= last_idx); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_fire |=> $stable(part_idx)); // R8

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && part_last) |=> (part_idx == '0)); // R8

  AST_LONG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == MODE_LONG) |-> (out_data == in_data && in_ready == out_ready)); // R7

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == MODE_BYTE) |-> (out_data[DATA_W-1:LANE_W] == '0)); // R9

  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode == MODE_WORD) |-> (out_data[DATA_W-1:WORD_W] == '0)); // R9

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == in_valid); // R10

endmodule

bind bus_width_adapter bwa_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_q     (cfg_q),
  .part_idx  (part_idx),
  .last_idx  (last_idx),
  .part_last (part_last),
  .beat_fire (beat_fire),
  .in_data   (in_data),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready)
);

// File: tb/sim_bus_width_adapter.sv
`timescale 1ns/1ps
module sim_bus_width_adapter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_narrow = 1'b0, cfg_byte = 1'b0, cfg_msb_first = 1'b0;
  logic [35:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_width_adapter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_narrow(cfg_narrow), .cfg_byte(cfg_byte),
    .cfg_msb_first(cfg_msb_first), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Transfers per long word from the pin settings (R1).
  function automatic int n_parts(input bit narrow, input bit bytesel);
    return !narrow ? 1 : (bytesel ? 4 : 2);
  endfunction

  // Expected k-th part via shift and mask (R3, R4, R9).
  function automatic logic [35:0] exp_part(input logic [35:0] d, input int n, input bit msb, input int k);
    int w = 36 / n;
    int slot = msb ? (n - 1 - k) : k;
    logic [63:0] wide = {28'h0, d} >> (slot * w);
    logic [63:0] mask = (w == 36) ? 64'h0000_000F_FFFF_FFFF : ((64'h1 << w) - 1);
    return 36'(wide & mask);
  endfunction

  task automatic apply_reset(input bit narrow, input bit bytesel, input bit msb);
    @(negedge clk);
    rst_n = 0; cfg_narrow = narrow; cfg_byte = bytesel; cfg_msb_first = msb;
    in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5: scramble the pins after release; latched values must rule.
    cfg_narrow = $urandom_range(0, 1); cfg_byte = $urandom_range(0, 1);
    cfg_msb_first = $urandom_range(0, 1);
    #1;
    chk(out_valid == 0, "R10 idle out_valid", 36'(out_valid), 36'h0);
    chk(in_ready == 0, "R6 idle in_ready", 36'(in_ready), 36'h0);
  endtask

  task automatic send_word(input logic [35:0] d, input int n, input bit msb, input bit stalls);
    for (int k = 0; k < n; k++) begin
      if (stalls && $urandom_range(0, 2) == 0) begin
        @(negedge clk);
        in_valid = 1; in_data = d; out_ready = 0;
        cfg_msb_first = ~cfg_msb_first; // R5 toggling pin mid-word
        #1;
        chk(out_data == exp_part(d, n, msb, k), "R8 stall holds part", out_data, exp_part(d, n, msb, k));
        chk(in_ready == 0, "R6 no pop on stall", 36'(in_ready), 36'h0);
        @(posedge clk);
      end
      @(negedge clk);
      in_valid = 1; in_data = d; out_ready = 1;
      #1;
      chk(out_data == exp_part(d, n, msb, k), msb ? "R3 part order" : "R4 part order",
          out_data, exp_part(d, n, msb, k));
      chk(in_ready == (k == n - 1), "R6 pop on last part", 36'(in_ready), 36'(k == n - 1));
      chk(out_valid == 1, "R10 valid follows", 36'(out_valid), 36'h1);
      if (n == 1) chk(out_data == d, "R7 passthrough", out_data, d);
      @(posedge clk);
    end
    if ($urandom_range(0, 3) == 0) begin
      @(negedge clk);
      in_valid = 0; out_ready = $urandom_range(0, 1);
      #1;
      chk(out_valid == 0, "R10 gap", 36'(out_valid), 36'h0);
      @(posedge clk);
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_2024));

    // Directed: R1/R2/R3 byte mode, MSB first, known pattern.
    apply_reset(1, 1, 1);
    send_word(36'h1_2345_6789, 4, 1, 0);
    chk(n_parts(1, 1) == 4, "R1 byte count", 36'(n_parts(1, 1)), 36'h4);

    // Directed: R4 word mode, LSB first.
    apply_reset(1, 0, 0);
    send_word(36'hA_BCDE_F012, 2, 0, 0);

    // Directed: R7 long mode with random stalls.
    apply_reset(0, 1, 1);
    send_word(36'hF_FFFF_FFFF, 1, 1, 1);

    // Directed: R8 reset mid-word returns to part 0.
    apply_reset(1, 1, 0);
    @(negedge clk); in_valid = 1; in_data = 36'h9_8765_4321; out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    apply_reset(1, 1, 0);
    @(negedge clk); in_valid = 1; in_data = 36'h9_8765_4321; out_ready = 0;
    #1;
    chk(out_data == 36'h121, "R8 cleared by reset", out_data, 36'h121);
    @(posedge clk);

    // Random: every configuration, random data and stalls.
    for (int c = 0; c < 6; c++) begin
      bit nar = (c >= 2);
      bit byt = (c >= 4);
      bit msb = c[0];
      apply_reset(nar, byt, msb);
      for (int w = 0; w < 25; w++) begin
        logic [35:0] d = {$urandom_range(0, 15), $urandom()};
        send_word(d, n_parts(nar, byt), msb, 1);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule